// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Tracker

This block watches a decoded SDRAM command stream and keeps, for every bank, the row state and the minimum-delay timers that decide whether the next command to that bank is legal. A command enters as a 3-bit code together with the address bit that picks between one bank and all banks, and a bank number. Each bank is in one of four states: closed, open, open with a self-closing access in flight, or closing. The block reports, per bank, whether a row is open and whether a new row may be opened. It also raises a one-cycle flag for every command that breaks the rules.

The three minimum delays are row-open-to-close, write recovery and close-to-reopen. They are given in nanoseconds and turned into clock cycles from a clock-period parameter. A read or write may ask, through the address bit, to close its own bank once the burst is done. A legal access to another bank cuts that wait short: a pending read closes in the same cycle, and a pending write closes one write-recovery time later.

A command that breaks a rule is dropped whole: it changes no bank state and only produces the flag. The block is meant to sit beside a memory controller or on a bus monitor as a protocol checker.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A synchronous active-high reset puts every bank in the closed state with all timers cleared: `bank_ready` all ones, `bank_open` all zeros, `viol` low.
- R2: Command codes on `cmd` are 0 idle, 1 open row, 2 read, 3 write, 4 close. An open-row command to a bank whose `bank_ready` bit is set makes, from the next cycle, `bank_open`=1 and `bank_ready`=0 for that bank. An open-row command to a bank that is not ready is a violation.
- R3: A read or write to a bank with no open row, to a bank that is closing, or to a bank with a self-closing access pending is a violation.
- R4: A close command with `a10`=1 addresses every bank and ignores `ba`. With `a10`=0 it addresses only bank `ba`. Every addressed open bank starts closing in the cycle the command is sampled.
- R5: A close command addressed to a bank that is already closed or already closing causes no violation and does not restart that bank's close-to-reopen timer.
- R6: A close command addressed to an open bank fewer than RAS cycles after its open-row command, or to a bank with a self-closing access pending, is a violation. If any addressed bank violates, a close-all is dropped for every bank.
- R7: A bank that starts closing in cycle p accepts an open-row command in cycle p+RP or later. Earlier, `bank_ready` is 0 and an open-row command is a violation.
- R8: `a10`=1 on a read or write arms self-closing for that command alone; with `a10`=0 the row stays open. An uninterrupted read sampled in cycle t starts closing in cycle t+BURST_LEN. A write starts closing in cycle t+BURST_LEN-1+WR. Neither starts before RAS cycles have passed since the open-row command.
- R9: A pending self-closing read starts closing in the cycle a legal read or write to another bank is sampled (still subject to RAS).
- R10: A pending self-closing write hit by a legal read or write to another bank in cycle u starts closing in cycle u+WR, or at its own earlier due cycle if that comes first.
- R11: Each delay in cycles is the nanosecond value divided by the clock period and rounded up. The defaults (45, 14 and 19 ns at 10 ns) give RAS=5, WR=2 and RP=2.
- R12: An illegal command raises `viol` for exactly the one cycle after it is sampled and changes no bank state. Legal commands and idle cycles leave `viol` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command code (0 idle, 1 open row, 2 read, 3 write, 4 close) |
| a10 | input | 1 | Close: all banks. Read/write: self-closing |
| ba | input | BA_W (2) | Bank number |
| bank_open | output | NUM_BANKS (4) | Per bank: a row is open |
| bank_ready | output | NUM_BANKS (4) | Per bank: an open-row command would be legal now |
| viol | output | 1 | One-cycle flag for an illegal command |

## Verification
The bench targets the edges of each timer. A close issued one cycle before RAS has elapsed must be flagged and the one issued at exactly RAS accepted. A design that rounds the delays down, or that is off by one cycle, fails there. A repeated close during the close-to-reopen window is aimed at designs that restart the timer: they would wrongly flag the reopen that follows two cycles later. Accesses to a second bank during a pending self-closing read or write check that the early close starts in the same cycle for reads and WR cycles later for writes. A long random stream is compared cycle by cycle against a timestamp-based model, to catch a dropped command that still changes state or a partly applied close-all.

// File: rtl/sdram_trk_pkg.sv
`timescale 1ns/1ps
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_APEND = 2'd2,
    BK_PRECH = 2'd3
  } bank_st_e;

  // ceiling of a delay in ns over the clock period in ns
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    return (t_ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
`timescale 1ns/1ps
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int RAS_C = 5,
  parameter int WR_C  = 2,
  parameter int RP_C  = 2,
  parameter int BL    = 4,
  parameter int CW    = 4
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  input  logic a10,
  input  logic sel,
  input  logic accept,
  input  logic other_acc,
  output logic bad,
  output logic is_open,
  output logic is_ready
);

  localparam logic [CW-1:0] RAS_LD   = CW'(RAS_C - 1);
  localparam logic [CW-1:0] RP_LD    = CW'(RP_C - 1);
  localparam logic [CW-1:0] WR_LD    = CW'(WR_C - 1);
  localparam logic [CW-1:0] AP_RD_LD = CW'(BL - 1);
  localparam logic [CW-1:0] AP_WR_LD = CW'(BL + WR_C - 2);

  bank_st_e        st;
  logic [CW-1:0]   ras_left, rp_left, ap_left;
  logic            ap_wr;

  // named events, used by the assertions below
  logic is_acc, addressed, ras_ok, rp_done;
  logic ap_rd_intr, ap_wr_intr, ap_fire, pre_go, act_go, ap_go;
  logic [CW-1:0] ap_dec, ap_nxt;

  assign is_acc     = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign addressed  = ((cmd == CMD_PRE) && a10) || sel;
  assign ras_ok     = (ras_left == '0);
  assign rp_done    = (st == BK_PRECH) && (rp_left == '0);
  assign is_ready   = (st == BK_IDLE) || rp_done;
  assign is_open    = (st == BK_OPEN) || (st == BK_APEND);

  assign ap_rd_intr = (st == BK_APEND) && !ap_wr && other_acc;
  assign ap_wr_intr = (st == BK_APEND) &&  ap_wr && other_acc;
  assign ap_fire    = (st == BK_APEND) && ras_ok && ((ap_left == '0) || ap_rd_intr);
  assign pre_go     = accept && (cmd == CMD_PRE) && addressed && (st == BK_OPEN);
  assign act_go     = accept && sel && (cmd == CMD_ACT);
  assign ap_go      = accept && sel && is_acc && a10;

  assign ap_dec = (ap_left == '0) ? '0 : ap_left - 1'b1;
  assign ap_nxt = (ap_wr_intr && (ap_dec > WR_LD)) ? WR_LD : ap_dec;

  always_comb begin
    case (cmd)
      CMD_ACT: bad = sel && !is_ready;
      CMD_RD,
      CMD_WR:  bad = sel && (st != BK_OPEN);
      CMD_PRE: bad = addressed && ((st == BK_APEND) || ((st == BK_OPEN) && !ras_ok));
      default: bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BK_IDLE;
      ras_left <= '0;
      rp_left  <= '0;
      ap_left  <= '0;
      ap_wr    <= 1'b0;
    end else begin
      if (act_go)
        ras_left <= RAS_LD;
      else if (!ras_ok)
        ras_left <= ras_left - 1'b1;

      if (act_go) begin
        st <= BK_OPEN;
      end else if (ap_go) begin
        st      <= BK_APEND;
        ap_wr   <= (cmd == CMD_WR);
        ap_left <= (cmd == CMD_WR) ? AP_WR_LD : AP_RD_LD;
      end else if (pre_go || ap_fire) begin
        st      <= BK_PRECH;
        rp_left <= RP_LD;
      end else if (st == BK_PRECH) begin
        if (rp_left == '0)
          st <= BK_IDLE;
        else
          rp_left <= rp_left - 1'b1;
      end else if (st == BK_APEND) begin
        ap_left <= ap_nxt;
      end
    end
  end

  // R5
  pre_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_PRECH && rp_left != '0 && cmd == CMD_PRE && addressed)
      |=> (st == BK_PRECH && rp_left == $past(rp_left) - 1'b1));

  // R8
  ap_ras_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BK_APEND && !ras_ok) |=> (st == BK_APEND));

  // R9
  rd_intr_chk: assert property (@(posedge clk) disable iff (rst)
    (ap_rd_intr && ras_ok) |=> (st == BK_PRECH && rp_left == RP_LD));

endmodule

// File: rtl/sdram_viol_merge.sv
`timescale 1ns/1ps
module sdram_viol_merge
  import sdram_trk_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic [NB-1:0] bad,
  output logic          accept,
  output logic          viol
);

  logic any_bad;
  assign any_bad = |bad;
  assign accept  = !any_bad;

  always_ff @(posedge clk) begin
    if (rst) viol <= 1'b0;
    else     viol <= any_bad;
  end

  // R12
  quiet_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NOP) |=> !viol);

endmodule

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RAS_NS      = 45,
  parameter int T_WR_NS       = 14,
  parameter int T_RP_NS       = 19,
  parameter int BURST_LEN     = 4,
  parameter int NUM_BANKS     = 4,
  localparam int BA_W         = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd,
  input  logic                 a10,
  input  logic [BA_W-1:0]      ba,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic                 viol
);

  // R11
  localparam int RAS_C = ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS);
  localparam int WR_C  = ns_to_cyc(T_WR_NS,  CLK_PERIOD_NS);
  localparam int RP_C  = ns_to_cyc(T_RP_NS,  CLK_PERIOD_NS);
  localparam int CMAX  = max3(RAS_C, RP_C, BURST_LEN + WR_C);
  localparam int CW    = $clog2(CMAX + 1);

  cmd_e                 cmd_t;
  logic [NUM_BANKS-1:0] sel, bad, other_acc;
  logic                 accept, is_acc;

  assign cmd_t  = cmd_e'(cmd);
  assign is_acc = (cmd_t == CMD_RD) || (cmd_t == CMD_WR);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign sel[i]       = (ba == BA_W'(i));
    assign other_acc[i] = accept && is_acc && !sel[i];

    sdram_bank_fsm #(
      .RAS_C(RAS_C), .WR_C(WR_C), .RP_C(RP_C), .BL(BURST_LEN), .CW(CW)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .cmd      (cmd_t),
      .a10      (a10),
      .sel      (sel[i]),
      .accept   (accept),
      .other_acc(other_acc[i]),
      .bad      (bad[i]),
      .is_open  (bank_open[i]),
      .is_ready (bank_ready[i])
    );
  end

  sdram_viol_merge #(.NB(NUM_BANKS)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd_t),
    .bad   (bad),
    .accept(accept),
    .viol  (viol)
  );

  // R3
  rdwr_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (is_acc && !bank_open[ba]) |=> viol);

endmodule

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/1ps
module tb_sdram_bank_tracker;

  localparam int NB  = 4;
  localparam int BL  = 4;
  localparam int RAS = int'($ceil(45.0 / 10.0));
  localparam int WRC = int'($ceil(14.0 / 10.0));
  localparam int RP  = int'($ceil(19.0 / 10.0));

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmd_i = NOP;
  logic a10_i = 1'b0;
  logic [1:0] ba_i = 2'd0;
  logic [NB-1:0] open_o, ready_o;
  logic viol_o;

  always #5 clk = ~clk;

  sdram_bank_tracker dut (
    .clk(clk), .rst(rst), .cmd(cmd_i), .a10(a10_i), .ba(ba_i),
    .bank_open(open_o), .bank_ready(ready_o), .viol(viol_o)
  );

  // timestamp-based scoreboard: 0 closed, 1 open, 2 self-close pending, 3 closing
  int m_st[NB], m_act[NB], m_pre[NB], m_due[NB];
  bit m_apwr[NB];
  int cyc = 0;
  bit exp_viol = 0;
  int checks = 0, fails = 0;

  function automatic bit m_ready(input int b, input int c);
    return (m_st[b] == 0) || (m_st[b] == 3 && c - m_pre[b] >= RP);
  endfunction

  always @(posedge clk) begin : model
    int c; bit bad, oth, rdi, wri;
    c = cyc;
    if (rst) begin
      for (int b = 0; b < NB; b++) m_st[b] = 0;
      exp_viol = 0;
    end else begin
      bad = 0;
      case (cmd_i)
        ACT: bad = !m_ready(ba_i, c);
        RD, WR: bad = (m_st[ba_i] != 1);
        PRE: for (int b = 0; b < NB; b++)
               if (a10_i || b == ba_i)
                 if (m_st[b] == 2 || (m_st[b] == 1 && c - m_act[b] < RAS)) bad = 1;
        default: bad = 0;
      endcase
      exp_viol = bad;
      oth = !bad && (cmd_i == RD || cmd_i == WR);
      for (int b = 0; b < NB; b++) begin
        if (m_st[b] == 2) begin
          rdi = oth && (b != ba_i) && !m_apwr[b];
          wri = oth && (b != ba_i) &&  m_apwr[b];
          if ((c >= m_due[b] || rdi) && (c - m_act[b] >= RAS)) begin
            m_st[b] = 3; m_pre[b] = c;
          end else if (wri && c + WRC < m_due[b]) begin
            m_due[b] = c + WRC;
          end
        end
      end
      if (!bad) begin
        case (cmd_i)
          ACT: begin m_st[ba_i] = 1; m_act[ba_i] = c; end
          RD, WR: if (a10_i) begin
            m_st[ba_i] = 2;
            m_apwr[ba_i] = (cmd_i == WR);
            m_due[ba_i] = (cmd_i == WR) ? c + BL - 1 + WRC : c + BL;
          end
          PRE: for (int b = 0; b < NB; b++)
                 if ((a10_i || b == ba_i) && m_st[b] == 1) begin
                   m_st[b] = 3; m_pre[b] = c;
                 end
          default: ;
        endcase
      end
    end
    cyc = cyc + 1;
  end

  task automatic compare(input string tag);
    logic [NB-1:0] eo, er;
    for (int b = 0; b < NB; b++) begin
      eo[b] = (m_st[b] == 1 || m_st[b] == 2);
      er[b] = m_ready(b, cyc);
    end
    checks++;
    if (open_o !== eo || ready_o !== er || viol_o !== exp_viol) begin
      fails++;
      $display("FAIL %s cyc=%0d open=%b exp %b ready=%b exp %b viol=%b exp %b",
               tag, cyc, open_o, eo, ready_o, er, viol_o, exp_viol);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic a, input int b, input string tag);
    cmd_i = c; a10_i = a; ba_i = 2'(b);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    @(negedge clk);
    idle(2, "R1");                        // reset state
    rst = 1'b0;
    idle(1, "R1");
    step(ACT, 0, 0, "R2");                // opens bank 0
    step(ACT, 0, 0, "R2");                // already open -> violation
    step(RD,  0, 1, "R3");                // closed bank
    step(WR,  1, 1, "R3");
    step(PRE, 0, 0, "R11");               // k=4 < RAS -> violation
    step(PRE, 0, 0, "R6");                // k=5 legal
    step(PRE, 0, 0, "R5");                // closing: NOP, timer kept
    step(ACT, 0, 0, "R5");                // k=RP -> legal only if not restarted
    idle(RAS, "R7");
    step(PRE, 0, 0, "R7");
    step(ACT, 0, 0, "R7");                // too early
    step(ACT, 0, 0, "R7");                // exactly RP
    for (int b = 1; b < NB; b++) step(ACT, 0, b, "R4");
    idle(RAS, "R4");
    step(PRE, 0, 2, "R4");                // bank 2 only
    step(PRE, 1, 2, "R4");                // all the rest
    idle(3, "R4");
    step(ACT, 0, 0, "R8");
    idle(RAS, "R8");
    step(RD, 1, 0, "R8");
    step(RD, 0, 0, "R3");                 // pending self-close -> violation
    idle(6, "R8");
    step(ACT, 0, 1, "R8");
    step(WR, 1, 1, "R8");
    step(PRE, 0, 1, "R6");                // pending -> violation
    idle(8, "R8");
    step(ACT, 0, 0, "R9");
    step(ACT, 0, 1, "R9");
    idle(RAS, "R9");
    step(RD, 1, 0, "R9");
    step(RD, 0, 1, "R9");                 // cuts bank 0 short
    idle(4, "R9");
    step(ACT, 0, 2, "R10");
    step(ACT, 0, 3, "R10");
    idle(RAS, "R10");
    step(WR, 1, 2, "R10");
    step(RD, 0, 3, "R10");                // bank 2 closes WR cycles later
    idle(6, "R10");
    step(PRE, 1, 0, "R10");
    idle(3, "R10");
    for (int i = 0; i < 4000; i++) begin
      step(3'($urandom % 5), ($urandom % 3) == 0, int'($urandom % NB), "R12");
    end
    finish_run();
  end

endmodule